// File: doc/BRIEF.md
# Branch Target Buffer with Speculative Local History

This block predicts the direction and target of branches for an instruction fetch unit. Branches are held in a set-associative table. The set is chosen by address bits just above the in-block offset, and each way stores a tag, the branch offset, a target address and two local histories. The committed history follows resolved outcomes. The speculative history follows the block's own predictions. Each set owns a pattern table of 2-bit saturating counters, and the history selects one of them.

A fetch lookup is combinational against the stored state. A hit shifts the predicted direction into the entry's speculative history on the next clock edge, so a later instance of the same branch sees that guess. The execution stage reports resolved branches on a separate port, and only those reports change the counters and the committed histories. A recovery pulse throws away every speculative history at once. After it, every entry predicts from its committed history again.

Top module: `spec_btb`

## Requirements
- R1: After reset no address hits, and every pattern counter holds 1 (weakly not-taken), so a newly allocated branch first predicts not-taken.
- R2: A lookup hits only when a valid way of the indexed set has an equal tag and an equal offset (offset = low OFF_W address bits, set = the next SET_W bits, tag = the rest). On a miss both `lk_taken` and `lk_target` are 0.
- R3: On a hit, `lk_taken` is 1 exactly when the selected counter of that set is 2 or 3, and `lk_target` is the stored target.
- R4: A lookup hit that is not cancelled by a same-cycle recovery replaces the speculative history with the selected history shifted left by one, with the predicted direction in bit 0, and marks it present.
- R5: The counter index is the speculative history when one is present for the entry, and the committed history otherwise.
- R6: A resolve that hits steps the counter indexed by the entry's old committed history toward the outcome, and shifts the outcome into the committed history. Lookups never change any counter.
- R7: A resolve hit with outcome taken stores the reported target. A not-taken outcome keeps the old target.
- R8: A resolve miss that is taken allocates an entry with both histories zero and no speculative history. An invalid way is chosen first, and otherwise a pseudo-random one. A resolve miss that is not taken allocates nothing.
- R9: `recover` discards every speculative history, so all entries predict from the committed copy. It wins over a lookup in the same cycle.
- R10: Counters saturate at 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Fetch lookup strobe |
| lk_addr | input | ADDR_W | Branch address being fetched |
| lk_hit | output | 1 | Lookup found an entry |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | ADDR_W | Predicted target |
| rs_valid | input | 1 | Resolved branch report |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome |
| rs_target | input | ADDR_W | Actual target |
| recover | input | 1 | Misprediction recovery pulse |

## Verification
The bench builds the block with 4 sets of 2 ways, 12-bit addresses and 2-bit offsets, and keeps the 4-bit history. With so few ways, a third branch mapped to one set forces a pseudo-random eviction, and the bench can see it by probing the residents. Two branches per set also let the invalid-way-first rule be seen. With the full 4-bit history, counters are trained at many indices in a few hundred operations. Random lookups, resolves and recoveries on that small address pool then run through the speculative-versus-committed selection and counter saturation many times.

// File: rtl/spec_btb_pkg.sv
package spec_btb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  // saturating step toward the outcome
  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  parameter int OFF_W = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][OFF_W-1:0] way_off,
  input  logic [TAG_W-1:0]           q_tag,
  input  logic [OFF_W-1:0]           q_off,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = way_valid[w] && (way_tag[w] == q_tag) && (way_off[w] == q_off);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [WAYS-1:0]  way_valid,
  output logic [WAY_W-1:0] victim
);
  logic [7:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (adv) lfsr_d = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= 8'h01;
    else        lfsr_q <= lfsr_d;
  end

  always_comb begin
    victim = WAY_W'(int'(lfsr_q) % WAYS);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/btb_pht.sv
module btb_pht
  import spec_btb_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int HIST_W = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int DEPTH = 2 ** HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);
  ctr_t tbl_q [SETS][DEPTH];
  ctr_t wr_val;

  assign rd_ctr = tbl_q[rd_set][rd_idx];
  assign wr_val = ctr_step(tbl_q[wr_set][wr_idx], wr_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int i = 0; i < DEPTH; i++)
          tbl_q[s][i] <= CTR_RESET;
    end else if (wr_en) begin
      tbl_q[wr_set][wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/spec_btb.sv
module spec_btb
  import spec_btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  logic              recover
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int ENT   = SETS * WAYS;
  localparam int ENT_W = $clog2(ENT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // entry state
  logic [ENT-1:0]    valid_q, valid_d, specv_q, specv_d;
  logic [TAG_W-1:0]  tag_q   [ENT];
  logic [OFF_W-1:0]  off_q   [ENT];
  logic [ADDR_W-1:0] tgt_q   [ENT];
  logic [HIST_W-1:0] chist_q [ENT];
  logic [HIST_W-1:0] shist_q [ENT];

  // address fields
  logic [OFF_W-1:0] lk_off, rs_off;
  logic [SET_W-1:0] lk_set, rs_set;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  assign lk_off = lk_addr[OFF_W-1:0];
  assign lk_set = lk_addr[OFF_W +: SET_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign rs_off = rs_addr[OFF_W-1:0];
  assign rs_set = rs_addr[OFF_W +: SET_W];
  assign rs_tag = rs_addr[ADDR_W-1 -: TAG_W];

  // per-way views of the two addressed sets
  logic [WAYS-1:0]            lk_wv, rs_wv;
  logic [WAYS-1:0][TAG_W-1:0] lk_wt, rs_wt;
  logic [WAYS-1:0][OFF_W-1:0] lk_wo, rs_wo;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_wv[w] = valid_q[int'(lk_set) * WAYS + w];
      lk_wt[w] = tag_q[int'(lk_set) * WAYS + w];
      lk_wo[w] = off_q[int'(lk_set) * WAYS + w];
      rs_wv[w] = valid_q[int'(rs_set) * WAYS + w];
      rs_wt[w] = tag_q[int'(rs_set) * WAYS + w];
      rs_wo[w] = off_q[int'(rs_set) * WAYS + w];
    end
  end

  logic             rs_hit;
  logic [WAY_W-1:0] lk_way, rs_way, vic_way;

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W)) lk_match_i (
    .way_valid(lk_wv), .way_tag(lk_wt), .way_off(lk_wo),
    .q_tag(lk_tag), .q_off(lk_off), .hit(lk_hit), .way(lk_way));

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W)) rs_match_i (
    .way_valid(rs_wv), .way_tag(rs_wt), .way_off(rs_wo),
    .q_tag(rs_tag), .q_off(rs_off), .hit(rs_hit), .way(rs_way));

  logic alloc;
  assign alloc = rs_valid && !rs_hit && rs_taken;

  btb_victim #(.WAYS(WAYS)) victim_i (
    .clk(clk), .rst_n(rst_s), .adv(alloc), .way_valid(rs_wv), .victim(vic_way));

  logic [ENT_W-1:0] lk_e, rs_e, al_e;
  assign lk_e = ENT_W'(int'(lk_set) * WAYS + int'(lk_way));
  assign rs_e = ENT_W'(int'(rs_set) * WAYS + int'(rs_way));
  assign al_e = ENT_W'(int'(rs_set) * WAYS + int'(vic_way));

  // prediction
  logic [HIST_W-1:0] sel_hist;
  ctr_t              rd_ctr;
  assign sel_hist  = specv_q[lk_e] ? shist_q[lk_e] : chist_q[lk_e];
  assign lk_taken  = lk_hit && rd_ctr[1];
  assign lk_target = lk_hit ? tgt_q[lk_e] : '0;

  logic rs_upd, lk_upd;
  assign rs_upd = rs_valid && rs_hit;
  assign lk_upd = lk_valid && lk_hit && !recover && !(alloc && (al_e == lk_e));

  btb_pht #(.SETS(SETS), .HIST_W(HIST_W)) pht_i (
    .clk(clk), .rst_n(rst_s),
    .rd_set(lk_set), .rd_idx(sel_hist), .rd_ctr(rd_ctr),
    .wr_en(rs_upd), .wr_set(rs_set), .wr_idx(chist_q[rs_e]), .wr_taken(rs_taken));

  // next state of the flag vectors
  always_comb begin
    valid_d = valid_q;
    specv_d = specv_q;
    if (alloc) begin
      valid_d[al_e] = 1'b1;
      specv_d[al_e] = 1'b0;
    end
    if (lk_upd) specv_d[lk_e] = 1'b1;
    if (recover) specv_d = '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      valid_q <= '0;
      specv_q <= '0;
    end else begin
      valid_q <= valid_d;
      specv_q <= specv_d;
    end
  end

  // entry payload, written under explicit enables
  always_ff @(posedge clk) begin
    if (lk_upd) shist_q[lk_e] <= {sel_hist[HIST_W-2:0], lk_taken};
    if (rs_upd) begin
      chist_q[rs_e] <= {chist_q[rs_e][HIST_W-2:0], rs_taken};
      if (rs_taken) tgt_q[rs_e] <= rs_target;
    end
    if (alloc) begin
      tag_q[al_e]   <= rs_tag;
      off_q[al_e]   <= rs_off;
      tgt_q[al_e]   <= rs_target;
      chist_q[al_e] <= '0;
      shist_q[al_e] <= '0;
    end
  end
endmodule

// File: rtl/spec_btb_chk.sv
module spec_btb_chk #(
  parameter int ADDR_W = 32,
  parameter int ENT    = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic              rs_valid,
  input logic              rs_hit,
  input logic              rs_taken,
  input logic              recover,
  input logic [ENT-1:0]    valid_q,
  input logic [ENT-1:0]    specv_q
);
  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_target == '0));

  a_r9_recover_clears: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> (specv_q == '0));

  a_r4_hit_marks_spec: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit && !recover) |=> (specv_q != '0));

  a_r8_no_alloc_nt_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit && !rs_taken) |=> $stable(valid_q));

  a_r8_valid_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(valid_q) & ~valid_q) == '0));

  a_r8_alloc_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit && rs_taken) |=> (valid_q != '0));
endmodule

bind spec_btb spec_btb_chk #(.ADDR_W(ADDR_W), .ENT(ENT)) chk_i (
  .clk(clk), .rst_n(rst_s), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_taken(lk_taken), .lk_target(lk_target), .rs_valid(rs_valid),
  .rs_hit(rs_hit), .rs_taken(rs_taken), .recover(recover),
  .valid_q(valid_q), .specv_q(specv_q));

// File: tb/spec_btb_tb_top.sv
module spec_btb_tb_top;
  localparam int AW = 12, OW = 2, NS = 4, NW = 2, HW = 4, NP = 8;

  logic clk, rst_n;
  logic lk_valid, lk_hit, lk_taken, rs_valid, rs_taken, recover;
  logic [AW-1:0] lk_addr, lk_target, rs_addr, rs_target;

  spec_btb #(.ADDR_W(AW), .OFF_W(OW), .SETS(NS), .WAYS(NW), .HIST_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
    .rs_target(rs_target), .recover(recover));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, fails = 0, cyc = 0;

  // independent model, keyed by pool index
  bit       m_val [NP];
  bit [AW-1:0] m_tgt [NP];
  bit [3:0] m_ch [NP], m_sh [NP];
  bit       m_sv [NP];
  int       m_pht [NS][16];

  function automatic bit [AW-1:0] pool_addr(int p);
    return {8'(8'h20 + p / NS), 2'(p % NS), 2'(p / NS)};
  endfunction

  function automatic int sat(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 0; rs_valid = 0; recover = 0;
    @(posedge clk);
  endtask

  // lookup of a pool entry, optionally with a same-cycle recovery
  task automatic look(int p, bit rec, string req);
    bit [3:0] h;
    bit exp_t;
    @(negedge clk);
    lk_valid = 1; lk_addr = pool_addr(p); rs_valid = 0; recover = rec;
    #1;
    h = m_sv[p] ? m_sh[p] : m_ch[p];
    exp_t = m_val[p] && (m_pht[p % NS][h] >= 2);
    chk(lk_hit == m_val[p], {req, " hit"}, lk_hit, m_val[p]);
    chk(lk_taken == exp_t, {req, " dir"}, lk_taken, exp_t);
    chk(lk_target == (m_val[p] ? m_tgt[p] : '0), {req, " target"},
        lk_target, m_val[p] ? m_tgt[p] : 0);
    if (m_val[p] && !rec) begin
      m_sh[p] = {h[2:0], exp_t};
      m_sv[p] = 1;
    end
    if (rec) for (int i = 0; i < NP; i++) m_sv[i] = 0;
    @(posedge clk);
  endtask

  task automatic resolve(int p, bit t, bit [AW-1:0] tgt);
    @(negedge clk);
    lk_valid = 0; recover = 0;
    rs_valid = 1; rs_addr = pool_addr(p); rs_taken = t; rs_target = tgt;
    if (m_val[p]) begin
      m_pht[p % NS][m_ch[p]] = sat(m_pht[p % NS][m_ch[p]], t);
      m_ch[p] = {m_ch[p][2:0], t};
      if (t) m_tgt[p] = tgt;
    end else if (t) begin
      m_val[p] = 1; m_tgt[p] = tgt; m_ch[p] = 0; m_sh[p] = 0; m_sv[p] = 0;
    end
    @(posedge clk);
  endtask

  task automatic flush();
    @(negedge clk);
    lk_valid = 0; rs_valid = 0; recover = 1;
    for (int i = 0; i < NP; i++) m_sv[i] = 0;
    @(posedge clk);
  endtask

  task automatic raw_look(bit [AW-1:0] a, output bit hit, output bit [AW-1:0] tg);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; rs_valid = 0; recover = 0;
    #1;
    hit = lk_hit; tg = lk_target;
    @(posedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    bit h; bit [AW-1:0] tg; int nres;
    void'($urandom(32'd2024));
    for (int i = 0; i < NP; i++) begin
      m_val[i] = 0; m_tgt[i] = 0; m_ch[i] = 0; m_sh[i] = 0; m_sv[i] = 0;
    end
    for (int s = 0; s < NS; s++) for (int i = 0; i < 16; i++) m_pht[s][i] = 1;
    lk_valid = 0; rs_valid = 0; recover = 0;
    lk_addr = 0; rs_addr = 0; rs_taken = 0; rs_target = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: empty after reset
    for (int p = 0; p < NP; p++) look(p, 0, "R1 reset");
    // R8: not-taken miss allocates nothing
    resolve(0, 0, 12'h111);
    look(0, 0, "R8 nt-miss");
    // R8/R1: taken miss allocates, first prediction weakly not-taken
    resolve(0, 1, 12'hA5C);
    look(0, 0, "R1 R8 alloc");
    // R2: other tag, other offset in the same set must miss
    raw_look({8'h7F, 2'd0, 2'd0}, h, tg);
    chk(!h && tg == 0, "R2 tag mismatch", h, 0);
    raw_look({8'h20, 2'd0, 2'd3}, h, tg);
    chk(!h && tg == 0, "R2 offset mismatch", h, 0);
    // R6/R7/R3: training, target kept on not-taken
    resolve(0, 1, 12'h3C4);
    resolve(0, 0, 12'hFFF);
    look(0, 0, "R7 target kept");
    for (int i = 0; i < 6; i++) resolve(0, 1, 12'h3C4);
    // R4/R5: speculative chain
    for (int i = 0; i < 5; i++) look(0, 0, "R4 R5 spec chain");
    // R9: recovery, then committed history used
    flush();
    look(0, 0, "R9 after recover");
    look(0, 1, "R9 same-cycle");
    look(0, 0, "R9 lookup dropped");
    // R10: saturation at 3 and back to 0
    for (int i = 0; i < 8; i++) resolve(4, 1, 12'h444);
    look(4, 0, "R10 high");
    for (int i = 0; i < 8; i++) resolve(4, 0, 12'h0);
    flush();
    look(4, 0, "R10 low");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 10);
      int p  = int'($urandom % NP);
      if (op < 5)       look(p, ($urandom % 16) == 0, "R3 R5 random");
      else if (op < 9)  resolve(p, ($urandom % 10) < 6, AW'($urandom));
      else              flush();
    end

    // R8: invalid way first, then eviction in set 3
    resolve(3, 1, 12'h333);
    resolve(7, 1, 12'h777);
    look(3, 0, "R8 both resident");
    look(7, 0, "R8 both resident");
    @(negedge clk);
    lk_valid = 0; recover = 0;
    rs_valid = 1; rs_addr = {8'h55, 2'd3, 2'd1}; rs_taken = 1; rs_target = 12'hBEE;
    @(posedge clk);
    raw_look({8'h55, 2'd3, 2'd1}, h, tg);
    chk(h && tg == 12'hBEE, "R8 evict alloc", tg, 12'hBEE);
    nres = 0;
    raw_look(pool_addr(3), h, tg); nres += h;
    raw_look(pool_addr(7), h, tg); nres += h;
    chk(nres == 1, "R8 one victim", nres, 1);
    idle();
    summary();
  end
endmodule